// File: doc/BRIEF.md
# Cache Range Maintenance Splitter

This block turns one byte-address maintenance request into the exact sequence of line and range commands that a level-2 cache controller accepts. A request carries a start address, an end address that is exclusive, and an operation: invalidate, clean, or flush. The splitter first aligns the request to cache lines. It then cuts the request into chunks that respect a per-command size cap and never cross a page. It presents each command on a command port and holds it there until the cache acknowledges it.

On an invalidate request, lines that the request covers only partly are never invalidated outright. Each of those edge lines receives a single-line clean-and-invalidate, so that neighbouring data in the same line survives. When the write-through override is set, the cache cannot hold dirty data, and every clean command is dropped.

After the last command the block raises a barrier request and waits for it to be acknowledged. It then pulses `done` for one cycle and returns to idle, ready for the next request.

Top module: `cache_range_splitter`

## Requirements
- R1: Every command address is line aligned (LINE_BYTES, default 32). A range command acts on every line whose first byte lies in the inclusive interval [cmd_lo, cmd_hi], with cmd_hi >= cmd_lo. A single-line command has cmd_hi equal to cmd_lo.
- R2: A range command covers at most MAX_BYTES (default 1024). Longer requests are issued as successive chunks in ascending address order.
- R3: A range command never crosses a PAGE_BYTES boundary (default 4096). Each chunk ends at the smallest of: the chunk start plus MAX_BYTES, the aligned request end, and the next page boundary.
- R4: The request end is exclusive. A range command carries cmd_hi equal to the chunk end minus LINE_BYTES.
- R5: For invalidate (req_op 2'b00), a start address that is not line aligned first produces a single-line clean-and-invalidate (cmd_op 2'd0) of the line that contains it. The working start then moves up to the next line boundary.
- R6: For invalidate, if the working start is still below the end and the end is not line aligned, the line that contains the end gets a single-line clean-and-invalidate. The end is then rounded down to a line boundary.
- R7: For invalidate, the remaining whole lines are covered only by invalidate-range commands (cmd_op 2'd1). An empty remainder issues none.
- R8: For clean (req_op 2'b01), the start is rounded down and the end is rounded up to line boundaries. Clean-range commands (cmd_op 2'd2) are then issued chunk by chunk until the start reaches the end.
- R9: For flush (req_op[1] set), the start and end are aligned in the same way as for clean. Each chunk receives a clean-range command followed by an invalidate-range command over the same interval.
- R10: wt_override is sampled when a request is accepted. If it is set, no clean-range command is issued: a clean request issues nothing, and a flush issues only its invalidate-range commands.
- R11: A command stays on the port, with cmd_op, cmd_lo and cmd_hi unchanged, until the cycle in which cmd_ack is high.
- R12: The barrier request is raised only after the last command has been acknowledged, and never while a command is pending. One cycle after bar_ack, done is high for exactly one cycle. The block is then idle with req_ready high, which is also its state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_op | input | 2 | 00 invalidate, 01 clean, 1x flush |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | Exclusive end byte address |
| wt_override | input | 1 | Write-through override, suppresses clean commands |
| cmd_valid | output | 1 | Command present on the port |
| cmd_op | output | 2 | 0 line clean+invalidate, 1 range invalidate, 2 range clean |
| cmd_lo | output | ADDR_W | First line address of the command |
| cmd_hi | output | ADDR_W | Inclusive last line address of the command |
| cmd_ack | input | 1 | Cache accepts the current command |
| bar_valid | output | 1 | Barrier request after the last command |
| bar_ack | input | 1 | Barrier completed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a chunk whose end is set by the page boundary rather than by the size cap or the request end. The same applies to an invalidate whose two edge lines fall in the same line, or whose head adjustment leaves no whole line. The bench runs the splitter with a 256-byte page and a 128-byte cap. It sweeps start addresses at an odd stride that is prime to the line size, against lengths placed just around the line, cap and page sizes, so that every cut rule and every edge-line case occurs many times. Acknowledge delays vary from command to command, so that holding a command under backpressure is exercised along the way.

// File: rtl/cache_range_splitter.sv
module cache_range_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_lo,
  output logic [ADDR_W-1:0] cmd_hi,
  input  logic              cmd_ack,
  output logic              bar_valid,
  input  logic              bar_ack,
  output logic              done
);
  localparam int XW = ADDR_W + 1;
  localparam logic [XW-1:0] LMX = XW'(LINE_BYTES - 1);
  localparam logic [XW-1:0] PMX = XW'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LMA = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] PMA = ADDR_W'(PAGE_BYTES - 1);
  localparam logic [1:0] C_LCI = 2'd0, C_RINV = 2'd1, C_RCLN = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_TAIL, S_RUN, S_BAR, S_FIN} st_t;
  st_t st;

  logic [XW-1:0] cur, lim, cap, pgn, ce;
  logic [1:0]    op;
  logic          wt, ph;

  wire is_inv    = (op == 2'b00);
  wire is_flush  = op[1];
  wire head_mis  = |(cur & LMX);
  wire tail_go   = |(lim & LMX) && (cur < lim);
  wire more      = is_inv ? (cur < lim) : (cur != lim);
  wire run_clean = !is_inv && !wt && !(is_flush && ph);
  wire [XW-1:0] req_s = {1'b0, req_start};
  wire [XW-1:0] req_e = {1'b0, req_end};

  assign cap = cur + XW'(MAX_BYTES);
  assign pgn = (cur | PMX) + XW'(1);

  always_comb begin
    ce = lim;
    if (ce > cap) ce = cap;
    if (ce > pgn) ce = pgn;
  end

  assign req_ready = (st == S_IDLE);
  assign bar_valid = (st == S_BAR);
  assign done      = (st == S_FIN);
  assign cmd_valid = (st == S_HEAD && head_mis) || (st == S_TAIL && tail_go) || (st == S_RUN && more);

  always_comb begin
    cmd_op = C_LCI;
    cmd_lo = ADDR_W'(cur & ~LMX);
    cmd_hi = cmd_lo;
    if (st == S_TAIL) begin
      cmd_lo = ADDR_W'(lim & ~LMX);
      cmd_hi = cmd_lo;
    end else if (st == S_RUN) begin
      cmd_op = run_clean ? C_RCLN : C_RINV;
      cmd_lo = ADDR_W'(cur);
      cmd_hi = ADDR_W'(ce - XW'(LINE_BYTES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cur <= '0;
      lim <= '0;
      op  <= 2'b00;
      wt  <= 1'b0;
      ph  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op;
          wt <= wt_override;
          ph <= 1'b0;
          if (req_op == 2'b00) begin
            cur <= req_s;
            lim <= req_e;
            st  <= S_HEAD;
          end else begin
            cur <= req_s & ~LMX;
            lim <= (req_e + LMX) & ~LMX;
            st  <= (req_op == 2'b01 && wt_override) ? S_BAR : S_RUN;
          end
        end
        S_HEAD: if (!head_mis) st <= S_TAIL;
                else if (cmd_ack) begin
                  cur <= (cur | LMX) + XW'(1);
                  st  <= S_TAIL;
                end
        S_TAIL: if (!tail_go) st <= S_RUN;
                else if (cmd_ack) begin
                  lim <= lim & ~LMX;
                  st  <= S_RUN;
                end
        S_RUN: if (!more) st <= S_BAR;
               else if (cmd_ack) begin
                 if (run_clean && is_flush) ph <= 1'b1;
                 else begin
                   cur <= ce;
                   ph  <= 1'b0;
                 end
               end
        S_BAR: if (bar_ack) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) && $stable(cmd_lo) && $stable(cmd_hi)); // R11
  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_lo & LMA) == '0) && ((cmd_hi & LMA) == '0) && (cmd_hi >= cmd_lo)); // R1
  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_hi - cmd_lo) < ADDR_W'(MAX_BYTES)); // R2
  AST_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_lo & ~PMA) == (cmd_hi & ~PMA)); // R3
  AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt |-> cmd_op != C_RCLN); // R10
  AST_BAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid |-> !cmd_valid && !req_ready); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R12
  AST_DONE_AFTER_BAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bar_valid && bar_ack)); // R12
endmodule

// File: tb/sim_cache_range_splitter.sv
module sim_cache_range_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LB = 32, MB = 128, PB = 256;
  localparam longint LM = LB - 1, PM = PB - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wt_override = 1'b0, cmd_ack = 1'b0, bar_ack = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_start = '0, req_end = '0;
  logic req_ready, cmd_valid, bar_valid, done;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_lo, cmd_hi;

  cache_range_splitter #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_BYTES(MB), .PAGE_BYTES(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .wt_override(wt_override), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_ack(cmd_ack), .bar_valid(bar_valid),
    .bar_ack(bar_ack), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, misses = 0;
  bit finished = 0;
  int e_op[64];
  longint e_lo[64], e_hi[64];
  string e_tag[64];
  int e_n;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(int o, longint lo, longint hi, string tag);
    if (e_n < 64) begin
      e_op[e_n] = o; e_lo[e_n] = lo; e_hi[e_n] = hi; e_tag[e_n] = tag;
    end
    e_n++;
  endtask

  function automatic longint chunk_end(longint s, longint e);
    longint c = e;
    if (c > s + MB) c = s + MB;
    if (c > (s | PM) + 1) c = (s | PM) + 1;
    return c;
  endfunction

  task automatic build(int op, longint s0, longint e0, bit wt);
    longint s, e, c;
    e_n = 0;
    if (op == 0) begin
      s = s0; e = e0;
      if ((s & LM) != 0) begin push(0, s & ~LM, s & ~LM, "R5"); s = (s | LM) + 1; end
      if (s < e && (e & LM) != 0) begin push(0, e & ~LM, e & ~LM, "R6"); e = e & ~LM; end
      while (s < e) begin c = chunk_end(s, e); push(1, s, c - LB, "R7 R2/R3"); s = c; end
    end else begin
      s = s0 & ~LM; e = (e0 + LM) & ~LM;
      while (s != e) begin
        c = chunk_end(s, e);
        if (!wt) push(2, s, c - LB, op == 1 ? "R8 R2/R3" : "R9 R10");
        if (op == 2) push(1, s, c - LB, wt ? "R9 R10" : "R9");
        s = c;
      end
    end
  endtask

  task automatic run_req(int op, longint s0, longint e0, bit wt);
    int idx = 0, guard = 0;
    build(op, s0, e0, wt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_start = AW'(s0); req_end = AW'(e0); wt_override = wt;
    @(negedge clk);
    req_valid = 1'b0; wt_override = ~wt;
    forever begin
      cmd_ack = 1'b0; bar_ack = 1'b0;
      guard++;
      if (guard > 2000) begin check(0, "R12", "no barrier", 0, 1); break; end
      if (cmd_valid) begin
        if (idx >= e_n || idx >= 64) check(0, "R10", "extra command", longint'(cmd_lo), -1);
        else begin
          check(int'(cmd_op) == e_op[idx], e_tag[idx], "cmd_op", cmd_op, e_op[idx]);
          check(longint'(cmd_lo) == e_lo[idx], e_tag[idx], "cmd_lo R1", cmd_lo, e_lo[idx]);
          check(longint'(cmd_hi) == e_hi[idx], {"R4 ", e_tag[idx]}, "cmd_hi", cmd_hi, e_hi[idx]);
        end
        repeat ((idx + vectors) % 3) begin
          @(negedge clk);
          check(cmd_valid && longint'(cmd_lo) == e_lo[idx % 64], "R11", "held cmd_lo", cmd_lo, e_lo[idx % 64]);
        end
        idx++;
        cmd_ack = 1'b1;
      end else if (bar_valid) begin
        check(idx == e_n, "R12", "commands before barrier", idx, e_n);
        bar_ack = 1'b1;
        @(negedge clk);
        bar_ack = 1'b0;
        check(done == 1'b1, "R12", "done pulse", done, 1);
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R12", "done one cycle then idle", {done, req_ready}, 1);
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int lens[12] = '{0, 1, 31, 32, 33, 100, 128, 129, 255, 256, 300, 513};
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0 && bar_valid == 1'b0 && done == 1'b0,
          "R12", "reset state", {req_ready, cmd_valid, bar_valid, done}, 4'b1000);
    rst_n = 1'b1;
    // R5 R6: both edges inside one line pair, R7 no whole lines left
    run_req(0, 40, 60, 0);
    run_req(0, 33, 95, 0);
    // R2 R3: page cut before cap, R8 R9 R10 variants
    run_req(1, 200, 500, 0);
    run_req(2, 200, 500, 0);
    run_req(2, 200, 500, 1);
    run_req(1, 200, 500, 1);
    for (int sa = 0; sa < 560; sa += 11)
      for (int li = 0; li < 12; li++)
        for (int op = 0; op < 3; op++)
          for (int w = 0; w < 2; w++)
            run_req(op, sa, sa + lens[li], w[0]);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule